// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is the control and address unit of a synchronous burst static RAM, built around a small on-chip word array. On every rising clock edge it reads three chip enables, a sleep request, two address strobes, a step input and the write-enable group. From these it picks one cycle kind: deselect, sleep, begin burst, continue burst or suspend burst. The cycle kind selects the word address. That address is the external address, the next address of a four-word burst group, or the current burst address reused.

The two strobes differ in two ways. The host-side strobe is ignored while the primary enable is inactive, and it always starts a read. The controller-side strobe deselects the chip when the primary enable is inactive, and it starts a write when the combined write signal is low. With both strobes idle, the step input either advances the burst or suspends it on the same word. Byte enables merge write data into the selected word. A read loads a registered data output. The data bus enable follows a read result and an output-enable input that is not clocked.

Top module: `sbsram_ctrl`

## Requirements
- R1: With `sleep_i` high at an edge, the cycle is a sleep cycle. After it, `bus_drv_o` is 0 and the array is unchanged, whatever the other inputs are.
- R2: With `cen_i` high and `strb_ctl_n_i` low, the cycle is a deselect: no array access, and `bus_drv_o` is 0 after the edge. With `cen_i` high and `strb_ctl_n_i` high, `strb_host_n_i` is ignored, so a live burst continues or suspends as the step input says.
- R3: With `cen_i` low but `ce_hi_i` low or `ce_lo_n_i` high, either strobe low gives a deselect. There is no write and `bus_drv_o` is 0 afterwards.
- R4: With the chip fully enabled (`cen_i`=0, `ce_hi_i`=1, `ce_lo_n_i`=0), `strb_host_n_i` low starts a read burst at `addr_i`, even if every write enable is low. This holds whatever state `strb_ctl_n_i` is in.
- R5: With the chip fully enabled, `strb_host_n_i` high and `strb_ctl_n_i` low, a burst starts at `addr_i`. It is a write when the combined write signal is low, and a read otherwise.
- R6: The combined write signal is low when `wr_all_n_i`=0, or when `wr_byte_n_i`=0 and at least one bit of `byte_sel_n_i` is 0. Otherwise it is high.
- R7: With both strobes high and `step_n_i` low, a live burst moves to the next word. When `ilv_i`=0 the low two address bits are (start + n) mod 4, where n is the number of steps since the burst began. The upper address bits stay those of the start address.
- R8: With `ilv_i`=1 the low two address bits of step n are start XOR (n mod 4).
- R9: With both strobes high and `step_n_i` high, the burst is suspended and the current word is accessed again. Continue and suspend cycles read or write according to the combined write signal.
- R10: On a write, byte b of the word (bits 8b+7..8b) is updated only when `byte_sel_n_i[b]`=0. When `wr_all_n_i`=0, all bytes are updated.
- R11: `bus_drv_o` is 1 only after a read cycle, and only while `out_en_n_i` is 0. It follows `out_en_n_i` without a clock edge and is 0 after write cycles.
- R12: Continue and suspend cycles that come after a deselect or a sleep cycle, before any new burst start, leave the array unchanged and keep `bus_drv_o` at 0.
- R13: During and right after reset, `bus_drv_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | Power-down sleep request, active high |
| cen_i | input | 1 | Primary chip enable, active low |
| ce_hi_i | input | 1 | Secondary chip enable, active high |
| ce_lo_n_i | input | 1 | Secondary chip enable, active low |
| strb_host_n_i | input | 1 | Host-side address strobe, active low, always starts a read |
| strb_ctl_n_i | input | 1 | Controller-side address strobe, active low |
| step_n_i | input | 1 | Burst step, low advances and high suspends |
| wr_all_n_i | input | 1 | Global write, active low, writes every byte |
| wr_byte_n_i | input | 1 | Byte-write enable, active low |
| byte_sel_n_i | input | NBYTES | Per-byte write selects, active low |
| ilv_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| out_en_n_i | input | 1 | Output enable, active low, not clocked |
| addr_i | input | ADDR_W | External word address |
| wdata_i | input | NBYTES*8 | Write data |
| rdata_o | output | NBYTES*8 | Registered read data |
| bus_drv_o | output | 1 | Data bus drive enable |

## Verification
On every cycle the assertions check these rules: the bus is quiet after sleep and deselect cycles, a host-strobe start is a read, a controller-strobe start under global write is a write, the output-enable gate holds, and a step that follows a deselect or sleep does not reach the array. The order of burst addresses (linear and interleaved, from every start position, with wrap and suspend) and the byte merging can only be shown by the bench. It writes the array through one cycle kind and reads it back through another, with an independent model of memory contents. The bench also sweeps every combination of partial chip enable and strobe, and every combination of the write-enable group.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    typedef enum logic [2:0] {
        CYC_DESEL = 3'd0,
        CYC_SLEEP = 3'd1,
        CYC_BEGIN = 3'd2,
        CYC_CONT  = 3'd3,
        CYC_SUSP  = 3'd4
    } cyc_e;

    // Low two address bits of a burst step: linear adds, interleaved XORs.
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] cnt,
                                             input logic       ilv);
        return ilv ? (start ^ cnt) : (start + cnt);
    endfunction

endpackage

// File: rtl/sbsram_decode.sv
module sbsram_decode
    import sbsram_pkg::*;
#(
    parameter int NBYTES = 2
) (
    input  logic              sleep,
    input  logic              cen,
    input  logic              ce_hi,
    input  logic              ce_lo_n,
    input  logic              sp_n,
    input  logic              sc_n,
    input  logic              step_n,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [NBYTES-1:0] be_n,
    output cyc_e              kind,
    output logic              is_wr,
    output logic [NBYTES-1:0] wmask
);

    logic full_en;
    logic wr_any;

    always_comb begin
        full_en = !cen && ce_hi && !ce_lo_n;
        wr_any  = !gw_n || (!bwe_n && (be_n != {NBYTES{1'b1}}));

        if (!gw_n)       wmask = {NBYTES{1'b1}};
        else if (!bwe_n) wmask = ~be_n;
        else             wmask = '0;

        kind  = CYC_SUSP;
        is_wr = 1'b0;
        if (sleep) begin
            kind = CYC_SLEEP;
        end else if (cen && !sc_n) begin
            kind = CYC_DESEL;
        end else if (!cen && !full_en && (!sp_n || !sc_n)) begin
            kind = CYC_DESEL;
        end else if (!cen && !sp_n) begin
            kind  = CYC_BEGIN;
            is_wr = 1'b0;
        end else if (!cen && !sc_n) begin
            kind  = CYC_BEGIN;
            is_wr = wr_any;
        end else begin
            kind  = step_n ? CYC_SUSP : CYC_CONT;
            is_wr = wr_any;
        end
    end

endmodule

// File: rtl/sbsram_burst.sv
module sbsram_burst
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cyc_e              kind,
    input  logic              ilv,
    input  logic [ADDR_W-1:0] addr_ext,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic              access
);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [1:0]        cnt;
        logic              live;
    } bst_t;

    bst_t st_d, st_q;
    logic [1:0] cnt_nx;

    always_comb begin
        st_d     = st_q;
        cnt_nx   = st_q.cnt + 2'd1;
        cyc_addr = addr_ext;
        access   = 1'b0;
        unique case (kind)
            CYC_BEGIN: begin
                st_d.base = addr_ext;
                st_d.cnt  = 2'd0;
                st_d.live = 1'b1;
                access    = 1'b1;
            end
            CYC_CONT: begin
                cyc_addr = {st_q.base[ADDR_W-1:2],
                            burst_low(st_q.base[1:0], cnt_nx, ilv)};
                access   = st_q.live;
                if (st_q.live) st_d.cnt = cnt_nx;
            end
            CYC_SUSP: begin
                cyc_addr = {st_q.base[ADDR_W-1:2],
                            burst_low(st_q.base[1:0], st_q.cnt, ilv)};
                access   = st_q.live;
            end
            default: begin
                st_d.live = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 2,
    parameter int BYTE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     access,
    input  logic                     is_wr,
    input  logic [NBYTES-1:0]        wmask,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NBYTES*BYTE_W-1:0] wdata,
    output logic [NBYTES*BYTE_W-1:0] rdata,
    output logic                     rd_live
);

    localparam int DATA_W = NBYTES * BYTE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef struct packed {
        logic              rd;
        logic [DATA_W-1:0] data;
    } rd_t;

    logic [DATA_W-1:0] mem [DEPTH];
    rd_t rd_d, rd_q;
    logic we;

    always_comb begin
        we      = access && is_wr;
        rd_d.rd = access && !is_wr;
        rd_d.data = rd_q.data;
        if (rd_d.rd) rd_d.data = mem[addr];
    end

    always_ff @(posedge clk) begin
        if (we) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (wmask[b]) mem[addr][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata   = rd_q.data;
    assign rd_live = rd_q.rd;

endmodule

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sleep_i,
    input  logic                  cen_i,
    input  logic                  ce_hi_i,
    input  logic                  ce_lo_n_i,
    input  logic                  strb_host_n_i,
    input  logic                  strb_ctl_n_i,
    input  logic                  step_n_i,
    input  logic                  wr_all_n_i,
    input  logic                  wr_byte_n_i,
    input  logic [NBYTES-1:0]     byte_sel_n_i,
    input  logic                  ilv_i,
    input  logic                  out_en_n_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [NBYTES*8-1:0]   wdata_i,
    output logic [NBYTES*8-1:0]   rdata_o,
    output logic                  bus_drv_o
);

    localparam int BYTE_W = 8;

    cyc_e              kind;
    logic              is_wr;
    logic [NBYTES-1:0] wmask;
    logic [ADDR_W-1:0] cyc_addr;
    logic              access;
    logic              rd_live;

    sbsram_decode #(.NBYTES(NBYTES)) u_dec (
        .sleep   (sleep_i),
        .cen     (cen_i),
        .ce_hi   (ce_hi_i),
        .ce_lo_n (ce_lo_n_i),
        .sp_n    (strb_host_n_i),
        .sc_n    (strb_ctl_n_i),
        .step_n  (step_n_i),
        .gw_n    (wr_all_n_i),
        .bwe_n   (wr_byte_n_i),
        .be_n    (byte_sel_n_i),
        .kind    (kind),
        .is_wr   (is_wr),
        .wmask   (wmask)
    );

    sbsram_burst #(.ADDR_W(ADDR_W)) u_bst (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (kind),
        .ilv      (ilv_i),
        .addr_ext (addr_i),
        .cyc_addr (cyc_addr),
        .access   (access)
    );

    sbsram_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .access  (access),
        .is_wr   (is_wr),
        .wmask   (wmask),
        .addr    (cyc_addr),
        .wdata   (wdata_i),
        .rdata   (rdata_o),
        .rd_live (rd_live)
    );

    // Output enable is not clocked: it gates the registered read flag directly.
    assign bus_drv_o = rd_live && !out_en_n_i;

endmodule

// File: rtl/sbsram_chk.sv
module sbsram_chk (
    input logic clk,
    input logic rst_n,
    input logic sleep_i,
    input logic cen_i,
    input logic ce_hi_i,
    input logic ce_lo_n_i,
    input logic strb_host_n_i,
    input logic strb_ctl_n_i,
    input logic wr_all_n_i,
    input logic out_en_n_i,
    input logic bus_drv_o,
    input logic rd_live
);

    logic full_en;
    assign full_en = !cen_i && ce_hi_i && !ce_lo_n_i;

    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> !bus_drv_o); // R1

    AST_CTL_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_i && cen_i && !strb_ctl_n_i) |=> !bus_drv_o); // R2

    AST_SEC_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_i && !cen_i && !full_en && (!strb_host_n_i || !strb_ctl_n_i)) |=> !bus_drv_o); // R3

    AST_HOST_READS: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_i && full_en && !strb_host_n_i) |=> rd_live); // R4

    AST_GLOBAL_WR_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_i && full_en && strb_host_n_i && !strb_ctl_n_i && !wr_all_n_i) |=> !rd_live); // R5

    AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n_i |-> !bus_drv_o); // R11

    AST_STEP_AFTER_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_i && strb_host_n_i && strb_ctl_n_i
         && $past(!sleep_i && cen_i && !strb_ctl_n_i)) |=> !rd_live); // R12

    AST_STEP_AFTER_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_i && strb_host_n_i && strb_ctl_n_i && $past(sleep_i)) |=> !rd_live); // R12

endmodule

bind sbsram_ctrl sbsram_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sleep_i       (sleep_i),
    .cen_i         (cen_i),
    .ce_hi_i       (ce_hi_i),
    .ce_lo_n_i     (ce_lo_n_i),
    .strb_host_n_i (strb_host_n_i),
    .strb_ctl_n_i  (strb_ctl_n_i),
    .wr_all_n_i    (wr_all_n_i),
    .out_en_n_i    (out_en_n_i),
    .bus_drv_o     (bus_drv_o),
    .rd_live       (rd_live)
);

// File: tb/sbsram_ctrl_tb.sv
module sbsram_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sleep_i = 1'b0, cen_i = 1'b1, ce_hi_i = 1'b1, ce_lo_n_i = 1'b0;
    logic        strb_host_n_i = 1'b1, strb_ctl_n_i = 1'b1, step_n_i = 1'b1;
    logic        wr_all_n_i = 1'b1, wr_byte_n_i = 1'b1;
    logic [1:0]  byte_sel_n_i = 2'b11;
    logic        ilv_i = 1'b0, out_en_n_i = 1'b0;
    logic [5:0]  addr_i = '0;
    logic [15:0] wdata_i = '0;
    logic [15:0] rdata_o;
    logic        bus_drv_o;

    int n_run = 0;
    int n_fail = 0;

    // bench model state
    logic [15:0] m_mem [64];
    logic [5:0]  m_base = '0;
    logic [1:0]  m_cnt = '0;
    logic        m_live = 1'b0;
    logic        m_rd = 1'b0;
    logic [15:0] m_rdata = '0;

    always #4 clk = ~clk;

    sbsram_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .cen_i(cen_i),
        .ce_hi_i(ce_hi_i), .ce_lo_n_i(ce_lo_n_i), .strb_host_n_i(strb_host_n_i),
        .strb_ctl_n_i(strb_ctl_n_i), .step_n_i(step_n_i), .wr_all_n_i(wr_all_n_i),
        .wr_byte_n_i(wr_byte_n_i), .byte_sel_n_i(byte_sel_n_i), .ilv_i(ilv_i),
        .out_en_n_i(out_en_n_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .bus_drv_o(bus_drv_o)
    );

    function automatic logic [15:0] pat(input int a);
        return 16'(a * 257) ^ 16'hA55A;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock cycle: drive, update the model per the requirements, check outputs.
    task automatic cyc(input bit slp, input bit cen, input bit chi, input bit clon,
                       input bit sp, input bit sc, input bit stp, input bit gw,
                       input bit bwe, input bit [1:0] be, input bit [5:0] a,
                       input bit [15:0] d, input string tag);
        int   kind;   // 0 desel/sleep, 1 begin, 2 continue, 3 suspend
        bit   via_host, wr_any, acc, wr;
        bit [1:0] mask, lo, c;
        bit [5:0] ca;
        @(negedge clk);
        sleep_i = slp; cen_i = cen; ce_hi_i = chi; ce_lo_n_i = clon;
        strb_host_n_i = sp; strb_ctl_n_i = sc; step_n_i = stp;
        wr_all_n_i = gw; wr_byte_n_i = bwe; byte_sel_n_i = be;
        addr_i = a; wdata_i = d;
        @(posedge clk);
        wr_any = !gw || (!bwe && be != 2'b11);               // R6
        mask = !gw ? 2'b11 : (!bwe ? ~be : 2'b00);
        via_host = 1'b0;
        if (slp) kind = 0;                                   // R1
        else if (cen && !sc) kind = 0;                       // R2
        else if (!cen && !(chi && !clon) && (!sp || !sc)) kind = 0; // R3
        else if (!cen && !sp) begin kind = 1; via_host = 1'b1; end  // R4
        else if (!cen && !sc) kind = 1;                      // R5
        else kind = stp ? 3 : 2;                             // R7 R9
        acc = 1'b0; wr = 1'b0; ca = a;
        case (kind)
            1: begin
                acc = 1'b1; wr = via_host ? 1'b0 : wr_any;
                m_base = a; m_cnt = 2'd0; m_live = 1'b1;
            end
            2, 3: begin
                if (m_live) begin                            // R12
                    if (kind == 2) m_cnt = m_cnt + 2'd1;
                    c  = m_cnt;
                    lo = ilv_i ? (m_base[1:0] ^ c) : (m_base[1:0] + c); // R7 R8
                    ca = {m_base[5:2], lo};
                    acc = 1'b1; wr = wr_any;
                end
            end
            default: m_live = 1'b0;
        endcase
        if (acc && wr) begin                                 // R10
            if (mask[0]) m_mem[ca][7:0]  = d[7:0];
            if (mask[1]) m_mem[ca][15:8] = d[15:8];
        end
        m_rd = acc && !wr;
        if (m_rd) m_rdata = m_mem[ca];
        #1;
        check({tag, " bus"}, {15'd0, bus_drv_o}, {15'd0, m_rd && !out_en_n_i}); // R11
        if (m_rd) check({tag, " data"}, rdata_o, m_rdata);
    endtask

    task automatic rd_host(input bit [5:0] a, input string tag);
        cyc(0, 0, 1, 0, 0, 1, 1, 0, 0, 2'b00, a, 16'hFFFF, tag);
    endtask

    task automatic wr_ctl(input bit [5:0] a, input bit [15:0] d, input bit gw,
                          input bit bwe, input bit [1:0] be, input string tag);
        cyc(0, 0, 1, 0, 1, 0, 1, gw, bwe, be, a, d, tag);
    endtask

    task automatic step(input bit stp, input bit gw, input bit [15:0] d, input string tag);
        cyc(0, 0, 1, 0, 1, 1, stp, gw, 1, 2'b11, 6'd0, d, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R13: reset state
        repeat (3) @(posedge clk);
        #1 check("R13 reset", {15'd0, bus_drv_o}, 16'd0);
        @(negedge clk) rst_n = 1'b1;
        #1 check("R13 after reset", {15'd0, bus_drv_o}, 16'd0);

        // R5: fill every word by controller-strobe global writes
        for (int a = 0; a < 64; a++) wr_ctl(6'(a), pat(a), 0, 1, 2'b11, "R5 fill");
        // R4: host strobe reads even with all write enables low; odd words with both strobes low
        for (int a = 0; a < 64; a++) begin
            if (a % 2 == 1) cyc(0, 0, 1, 0, 0, 0, 1, 0, 0, 2'b00, 6'(a), 16'h0, "R4 both strobes");
            else            rd_host(6'(a), "R4 host read");
        end

        // R7 R8 R9: read bursts from every start, both orders, with suspend and wrap
        for (int o = 0; o < 2; o++) begin
            for (int s = 0; s < 4; s++) begin
                ilv_i = o[0];
                rd_host(6'(16 + 4 * s + s), o ? "R8 start" : "R7 start");
                for (int k = 0; k < 3; k++) step(0, 1, 16'h0, o ? "R8 step" : "R7 step");
                step(1, 1, 16'h0, "R9 suspend");
                step(0, 1, 16'h0, o ? "R8 wrap" : "R7 wrap");
            end
        end
        // R7 R8: write bursts then read back through host strobe
        for (int o = 0; o < 2; o++) begin
            for (int s = 0; s < 4; s++) begin
                ilv_i = o[0];
                wr_ctl(6'(40 + s), 16'h1000 + 16'(o * 16 + s * 4), 0, 1, 2'b11, "R5 burst wr");
                for (int k = 1; k < 4; k++)
                    step(0, 0, 16'h1000 + 16'(o * 16 + s * 4 + k), o ? "R8 wr step" : "R7 wr step");
                step(1, 0, 16'h2000 + 16'(o * 16 + s), "R9 wr suspend");
                for (int a = 40; a < 44; a++) rd_host(6'(a), "R9 wr readback");
            end
        end
        ilv_i = 1'b0;

        // R6 R10: every write-enable combination, then read back
        for (int gw = 0; gw < 2; gw++)
            for (int bwe = 0; bwe < 2; bwe++)
                for (int be = 0; be < 4; be++) begin
                    wr_ctl(6'd20, 16'h3C00 + 16'(gw * 64 + bwe * 16 + be * 4 + 16'h0101),
                           gw[0], bwe[0], be[1:0], "R6 R10 byte wr");
                    rd_host(6'd20, "R10 readback");
                end

        // R2: primary enable off with controller strobe -> deselect, no write
        wr_ctl(6'd5, 16'h0, 0, 1, 2'b11, "R2 setup");
        cyc(0, 1, 1, 0, 1, 0, 1, 0, 0, 2'b00, 6'd5, 16'hDEAD, "R2 ctl desel");
        rd_host(6'd5, "R2 no write");
        // R2: host strobe ignored with primary enable off
        rd_host(6'd7, "R2 burst start");
        cyc(0, 1, 1, 0, 0, 1, 1, 1, 1, 2'b11, 6'd30, 16'h0, "R2 host ignored suspend");
        cyc(0, 1, 1, 0, 0, 1, 0, 1, 1, 2'b11, 6'd30, 16'h0, "R2 host ignored step");

        // R3 R12: partial enables with each strobe mix, then steps that must not write
        for (int e = 0; e < 3; e++)
            for (int sm = 0; sm < 3; sm++) begin
                rd_host(6'd12, "R3 setup");
                cyc(0, 0, e == 1 ? 1'b0 : e == 0 ? 1'b0 : 1'b1, e == 0 ? 1'b0 : 1'b1,
                    sm == 1 ? 1'b1 : 1'b0, sm == 0 ? 1'b1 : 1'b0, 1,
                    0, 0, 2'b00, 6'd12, 16'hBEEF, "R3 sec desel");
                step(0, 0, 16'hCAFE, "R12 step after desel");
                step(1, 0, 16'hCAFE, "R12 suspend after desel");
                rd_host(6'd12, "R12 unchanged");
                rd_host(6'd13, "R12 unchanged next");
            end

        // R1 R12: sleep with everything asserted, then steps
        rd_host(6'd9, "R1 setup");
        cyc(1, 0, 1, 0, 0, 0, 0, 0, 0, 2'b00, 6'd9, 16'h0BAD, "R1 sleep");
        cyc(1, 1, 0, 1, 1, 1, 1, 0, 0, 2'b00, 6'd9, 16'h0BAD, "R1 sleep idle");
        step(0, 0, 16'h0BAD, "R12 step after sleep");
        rd_host(6'd9, "R1 no write");
        rd_host(6'd10, "R12 next word unchanged");

        // R11: output enable gating without a clock edge
        out_en_n_i = 1'b1;
        rd_host(6'd3, "R11 oe off");
        #1 out_en_n_i = 1'b0;
        #1 check("R11 async on", {15'd0, bus_drv_o}, 16'd1);
        out_en_n_i = 1'b1;
        #1 check("R11 async off", {15'd0, bus_drv_o}, 16'd0);
        out_en_n_i = 1'b0;
        wr_ctl(6'd3, 16'h7777, 0, 1, 2'b11, "R11 write masks");
        rd_host(6'd3, "R11 read after write");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule